// File: doc/BRIEF.md
# Program Counter and Return Stack Sequencer

The block decides where the next instruction comes from. It holds a 16-bit program counter, an 8-bit upper-address latch and a 16-entry hardware return stack. Each clock it looks at the instruction word fetched from the current address and picks one of these: step to the next word, step past one word on a skip request, jump or call within the current 8K-word page, make a long call built from the latch, return, return with a literal, or return from interrupt.

Page-relative jumps and calls replace only the low 13 address bits and keep the top three. They also reload the upper-address latch, so a later long call can reach any 256-word block in the 64K space. A return restores the address and leaves the latch alone. A return from interrupt also re-enables interrupts by clearing the global disable output. Instruction memory and the interrupt arbiter sit outside the block.

Top module: `pc_sequencer`

## Requirements
- R1: After reset, fetchAddr is 0x0000, retLiteral is 0x00, intDisable is 1 and the return stack is empty.
- R2: An instruction word that is not a control word (see R4, R6, R7, R8, R9, R10) with skipReq low advances fetchAddr by one on the next clock.
- R3: With skipReq high, a non-control word advances fetchAddr by two. skipReq has no effect when the word is a control word.
- R4: A word whose bits 15:13 are 3'b110 (top nibble 0xC or 0xD) is a short goto. fetchAddr takes word bits 12:0 into bits 12:0 and keeps its own bits 15:13.
- R5: A short goto or short call loads the upper-address latch with word bits 12:8 in latch bits 4:0 and the current address bits 15:13 in latch bits 7:5. The latch is seen at the ports through a later long call.
- R6: A word whose bits 15:13 are 3'b111 (top nibble 0xE or 0xF) is a short call. It pushes fetchAddr+1 onto the return stack and then jumps exactly as in R4.
- R7: A word 0xB7kk is a long call. It pushes fetchAddr+1, and fetchAddr becomes {latch, kk}.
- R8: The word 0x0002 is a return. fetchAddr becomes the popped top of stack and the latch is unchanged.
- R9: A word 0xB6kk is a return with literal. It pops into fetchAddr as in R8 and sets retLiteral to kk, which then holds until the next such word.
- R10: The word 0x0005 is a return from interrupt. It pops into fetchAddr as in R8 and clears intDisable. No word sets intDisable again.
- R11: The return stack is 16 deep and circular. A 17th nested push overwrites the oldest entry, and a pop from an empty stack wraps to the last slot. No error is flagged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr | input | 16 | Instruction word fetched from fetchAddr |
| skipReq | input | 1 | Request to step past the next word |
| fetchAddr | output | 16 | Program counter, the address of the current word |
| retLiteral | output | 8 | Literal captured by the last return-with-literal |
| intDisable | output | 1 | Global interrupt disable, cleared by return from interrupt |

## Verification
The bench builds the block with its default parameters: a 16-bit counter, a 13-bit page, an 8-bit latch and a 16-entry stack. With these values a run of 17 nested calls is enough to overrun the stack and show the wrap of R11. Stepping forward from 0x1FFE crosses into the second page, so the page-preserving rule of R4 and the latch's page bits in R5 are tested with non-zero upper bits. A long stream of pseudo-random words then mixes every operation against the behavioural model.

// File: rtl/seq_pkg.sv
package seq_pkg;

  // Strobes passed from the decoder to the datapath and the stack
  typedef struct packed {
    logic jumpShort;   // page-relative jump (goto or call)
    logic push;        // push return address
    logic jumpLong;    // latch-based long call
    logic pop;         // pop top of stack into the PC
    logic loadLit;     // capture literal on return
    logic clrIntDis;   // clear global interrupt disable
    logic skip;        // step by two
  } seqStrobe_t;

endpackage

// File: rtl/seq_control.sv
module seq_control
  import seq_pkg::*;
#(
  parameter int INSTR_W = 16,
  parameter int LIT_W   = 8
) (
  input  logic [INSTR_W-1:0] instr,
  input  logic               skipReq,
  output seqStrobe_t         strb
);

  localparam int TOP_W = 3;
  localparam int HI_W  = INSTR_W - LIT_W;

  localparam logic [TOP_W-1:0]   GOTO_TOP  = 3'b110;
  localparam logic [TOP_W-1:0]   CALL_TOP  = 3'b111;
  localparam logic [HI_W-1:0]    LCALL_HI  = 8'hB7;
  localparam logic [HI_W-1:0]    RETLW_HI  = 8'hB6;
  localparam logic [INSTR_W-1:0] RET_WORD  = 16'h0002;
  localparam logic [INSTR_W-1:0] RTI_WORD  = 16'h0005;

  logic isGoto, isCall, isLcall, isRetlw, isRet, isRti, isCtrl;

  always_comb begin
    isGoto  = (instr[INSTR_W-1 -: TOP_W] == GOTO_TOP);
    isCall  = (instr[INSTR_W-1 -: TOP_W] == CALL_TOP);
    isLcall = (instr[INSTR_W-1 -: HI_W] == LCALL_HI);
    isRetlw = (instr[INSTR_W-1 -: HI_W] == RETLW_HI);
    isRet   = (instr == RET_WORD);
    isRti   = (instr == RTI_WORD);
    isCtrl  = isGoto | isCall | isLcall | isRetlw | isRet | isRti;

    strb.jumpShort = isGoto | isCall;
    strb.push      = isCall | isLcall;
    strb.jumpLong  = isLcall;
    strb.pop       = isRet | isRetlw | isRti;
    strb.loadLit   = isRetlw;
    strb.clrIntDis = isRti;
    strb.skip      = skipReq & ~isCtrl;
  end

  always_comb begin
    p_onehot_jump_r4: assert ($onehot0({strb.jumpShort, strb.jumpLong, strb.pop, strb.skip}));
  end

endmodule

// File: rtl/seq_stack.sv
module seq_stack #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] pushData,
  output logic [DATA_W-1:0] topData
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  sp;       // next free slot
  logic [PTR_W-1:0]  spInc, spDec;

  always_comb begin
    spInc = (sp == LAST) ? '0 : sp + 1'b1;
    spDec = (sp == '0) ? LAST : sp - 1'b1;
  end

  assign topData = mem[spDec];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (push) begin
      mem[sp] <= pushData;
      sp      <= spInc;
    end else if (pop) begin
      sp <= spDec;
    end
  end

  logic validQ;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) validQ <= 1'b0;
    else        validQ <= 1'b1;
  end

  p_lifo_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
    validQ && $past(push) |-> topData == $past(pushData));

  p_wrap_ptr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    push && sp == LAST |=> sp == '0);

  p_no_push_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && pop));

endmodule

// File: rtl/seq_datapath.sv
module seq_datapath
  import seq_pkg::*;
#(
  parameter int PC_W    = 16,
  parameter int PAGE_W  = 13,
  parameter int LATCH_W = 8,
  parameter int LIT_W   = 8,
  parameter int INSTR_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  seqStrobe_t         strb,
  input  logic [INSTR_W-1:0] instr,
  input  logic [PC_W-1:0]    topData,
  output logic [PC_W-1:0]    pc,
  output logic [PC_W-1:0]    pushData,
  output logic [LIT_W-1:0]   retLiteral,
  output logic               intDisable
);

  localparam int HI_W  = PC_W - PAGE_W;      // page bits kept by short jumps
  localparam int LLO_W = LATCH_W - HI_W;     // latch bits loaded from target

  logic [LATCH_W-1:0] latch;
  logic [PC_W-1:0]    pcNext;
  logic [LATCH_W-1:0] latchNext;

  assign pushData = pc + 1'b1;

  always_comb begin
    if (strb.jumpShort)     pcNext = {pc[PC_W-1 -: HI_W], instr[PAGE_W-1:0]};
    else if (strb.jumpLong) pcNext = {latch, instr[LIT_W-1:0]};
    else if (strb.pop)      pcNext = topData;
    else if (strb.skip)     pcNext = pc + PC_W'(2);
    else                    pcNext = pc + 1'b1;

    latchNext = strb.jumpShort ? {pc[PC_W-1 -: HI_W], instr[PAGE_W-1 -: LLO_W]} : latch;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc         <= '0;
      latch      <= '0;
      retLiteral <= '0;
      intDisable <= 1'b1;
    end else begin
      pc    <= pcNext;
      latch <= latchNext;
      if (strb.loadLit)   retLiteral <= instr[LIT_W-1:0];
      if (strb.clrIntDis) intDisable <= 1'b0;
    end
  end

  logic validQ;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) validQ <= 1'b0;
    else        validQ <= 1'b1;
  end

  p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    validQ && $past(!strb.jumpShort && !strb.jumpLong && !strb.pop && !strb.skip)
      |-> pc == $past(pc) + 1'b1);

  p_skip_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    validQ && $past(strb.skip) |-> pc == $past(pc) + PC_W'(2));

  p_page_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    validQ && $past(strb.jumpShort) |->
      pc[PC_W-1 -: HI_W] == $past(pc[PC_W-1 -: HI_W]) && pc[PAGE_W-1:0] == $past(instr[PAGE_W-1:0]));

  p_long_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
    validQ && $past(strb.jumpLong) |-> pc == {$past(latch), $past(instr[LIT_W-1:0])});

  p_latch_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    validQ && $past(strb.pop) |-> latch == $past(latch));

  p_lit_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    validQ && $past(!strb.loadLit) |-> retLiteral == $past(retLiteral));

  p_intdis_never_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(intDisable));

  p_intdis_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    validQ && $fell(intDisable) |-> $past(strb.clrIntDis));

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import seq_pkg::*;
#(
  parameter int PC_W    = 16,
  parameter int PAGE_W  = 13,
  parameter int LIT_W   = 8,
  parameter int DEPTH   = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] instr,
  input  logic            skipReq,
  output logic [PC_W-1:0] fetchAddr,
  output logic [LIT_W-1:0] retLiteral,
  output logic            intDisable
);

  localparam int LATCH_W = PC_W - LIT_W;

  seqStrobe_t      strb;
  logic [PC_W-1:0] topData;
  logic [PC_W-1:0] pushData;

  seq_control #(.INSTR_W(PC_W), .LIT_W(LIT_W)) u_ctrl (
    .instr   (instr),
    .skipReq (skipReq),
    .strb    (strb)
  );

  seq_datapath #(
    .PC_W(PC_W), .PAGE_W(PAGE_W), .LATCH_W(LATCH_W), .LIT_W(LIT_W), .INSTR_W(PC_W)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strb       (strb),
    .instr      (instr),
    .topData    (topData),
    .pc         (fetchAddr),
    .pushData   (pushData),
    .retLiteral (retLiteral),
    .intDisable (intDisable)
  );

  seq_stack #(.DEPTH(DEPTH), .DATA_W(PC_W)) u_stack (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (strb.push),
    .pop      (strb.pop),
    .pushData (pushData),
    .topData  (topData)
  );

endmodule

// File: tb/pc_sequencer_tb.sv
module pc_sequencer_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] instr = 16'h0000;
  logic        skipReq = 1'b0;
  logic [15:0] fetchAddr;
  logic [7:0]  retLiteral;
  logic        intDisable;

  always #2.5 clk = ~clk;   // 200 MHz

  pc_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .instr(instr), .skipReq(skipReq),
    .fetchAddr(fetchAddr), .retLiteral(retLiteral), .intDisable(intDisable)
  );

  // behavioural reference
  int mPc, mLatch, mLit, mIntDis, mSp;
  int mStk [16];
  int vectors = 0;
  int fails = 0;
  int cycles = 0;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: actual cycles=%0d expected below 100000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic compare(input string tag);
    vectors++;
    if (fetchAddr !== 16'(mPc)) begin
      fails++;
      $display("FAIL %s fetchAddr actual=%h expected=%h", tag, fetchAddr, 16'(mPc));
    end
    if (retLiteral !== 8'(mLit)) begin
      fails++;
      $display("FAIL %s retLiteral actual=%h expected=%h", tag, retLiteral, 8'(mLit));
    end
    if (intDisable !== 1'(mIntDis)) begin
      fails++;
      $display("FAIL %s intDisable actual=%b expected=%b", tag, intDisable, 1'(mIntDis));
    end
  endtask

  task automatic mPush(input int v);
    mStk[mSp] = v & 16'hFFFF;
    mSp = (mSp + 1) % 16;
  endtask

  task automatic mPop();
    mSp = (mSp + 15) % 16;
    mPc = mStk[mSp];
  endtask

  // apply one word at the falling edge, advance the model, check after the next rising edge
  task automatic step(input logic [15:0] w, input logic sk, input string tag);
    instr   = w;
    skipReq = sk;
    if (w[15:13] == 3'b110 || w[15:13] == 3'b111) begin
      if (w[15:13] == 3'b111) mPush(mPc + 1);
      mLatch = ((mPc >> 13) << 5) | int'(w[12:8]);
      mPc    = (mPc & 16'hE000) | int'(w[12:0]);
    end else if (w[15:8] == 8'hB7) begin
      mPush(mPc + 1);
      mPc = (mLatch << 8) | int'(w[7:0]);
    end else if (w[15:8] == 8'hB6) begin
      mPop();
      mLit = int'(w[7:0]);
    end else if (w == 16'h0002) begin
      mPop();
    end else if (w == 16'h0005) begin
      mPop();
      mIntDis = 0;
    end else begin
      mPc = (mPc + (sk ? 2 : 1)) & 16'hFFFF;
    end
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    mPc = 0; mLatch = 0; mLit = 0; mIntDis = 1; mSp = 0;
    for (int i = 0; i < 16; i++) mStk[i] = 0;
    repeat (3) @(negedge clk);
    compare("R1");                       // reset state
    rst_n = 1'b1;

    // R2: plain stepping
    for (int i = 0; i < 4; i++) step(16'h1234 + 16'(i), 1'b0, "R2");
    // R3: skip on plain words, then skip ignored on a goto
    step(16'h0000, 1'b1, "R3");
    step(16'h0777, 1'b1, "R3");
    step(16'hC040, 1'b1, "R3_ignored_on_goto");
    // R4/R5: goto near the page edge, cross into page 1
    step(16'hDFFE, 1'b0, "R4");
    step(16'h0000, 1'b0, "R2");
    step(16'h0000, 1'b0, "R2_page_cross");
    step(16'hC005, 1'b0, "R4_page_kept");
    // R7 using latch = {001,00000}
    step(16'hB711, 1'b0, "R5_R7");
    // R6 short call, R8 return
    step(16'hEABC, 1'b0, "R6");
    step(16'hB7FF, 1'b0, "R7");
    step(16'h0002, 1'b0, "R8");
    step(16'hB7AA, 1'b0, "R8_latch_kept");
    step(16'hB655, 1'b0, "R9");
    step(16'h0100, 1'b0, "R9_hold");
    step(16'h0002, 1'b0, "R8");
    // R10 return from interrupt
    step(16'hF123, 1'b0, "R6");
    step(16'h0005, 1'b0, "R10");
    step(16'h0000, 1'b0, "R10_stays_clear");
    // R11 overrun: 17 nested calls, then 17 returns
    for (int i = 0; i < 17; i++) step(16'hE300 + 16'(2 * i), 1'b0, "R11_push");
    for (int i = 0; i < 17; i++)
      step((i % 2) ? 16'h0002 : (16'hB600 | 16'(i)), 1'b0, "R11_pop");
    step(16'h0002, 1'b0, "R11_underflow");
    // mixed stream
    for (int i = 0; i < 400; i++) begin
      logic [15:0] w;
      int sel;
      sel = $urandom % 8;
      case (sel)
        0: w = 16'h0002;
        1: w = 16'hB600 | 16'($urandom % 256);
        2: w = 16'hB700 | 16'($urandom % 256);
        3: w = 16'hC000 | 16'($urandom % 8192);
        4: w = 16'hE000 | 16'($urandom % 8192);
        5: w = 16'h0005;
        default: w = 16'($urandom % 16'hB000);
      endcase
      step(w, 1'($urandom % 2), "R2_R3_R4_R6_R7_R8_R9_mix");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule